// File: doc/BRIEF.md
# Trigger-Matched Pixel Hit Pipeline

This block is the digital model of one pixel's hit history and its trigger match. On every bunch-crossing clock it stores the pixel's discriminator hit bit in a ring of cells, one cell per crossing, whether or not a hit occurred. In the same cycle it reads the cell just ahead of the write position. That cell holds the bit written one full lap of the ring earlier. The ring depth therefore fixes the trigger latency: with the default 120 cells at 25 ns per crossing, 3 µs of history is kept.

When the cell being read holds a hit and a level-1 trigger is present in that cycle, a sticky flag is set. The flag drives this pixel's share of a wired OR along its row and of a wired OR along its column. Readout logic finds the pixel through these ORs, selects it and then erases the flag. The write and read positions model controls that the whole matrix shares; they are generated once in a small controller.

Top module: `pixel_hit_pipeline`

## Requirements
- R1: After reset every cell is empty, the write position is cell 0 and the flag is clear. All outputs are 0, and a trigger held for the first full lap after reset sets nothing.
- R2: A cell is written on every clock whether the hit input is 0 or 1. The write position steps by one and wraps from DEPTH-1 to 0, so the match latency stays the same across every wrap.
- R3: A hit sampled at clock edge k is matched by a trigger sampled at edge k+DEPTH-1 (119 edges later by default). The flag is visible after that edge.
- R4: The flag is set only when the trigger and a stored hit meet in the same cycle. A trigger one cycle early or one cycle late against that hit has no effect, and so does a trigger with no stored hit.
- R5: Once set, the flag stays set until a cycle with clear and readout select both high. After that edge it is 0.
- R6: Clear while the readout select is low has no effect on the flag.
- R7: If a trigger match and a selected clear occur in the same cycle, the flag is 1 after the edge.
- R8: row_or_o and col_or_o both equal the flag. rd_data_o equals the flag while rd_sel_i is high and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hit_i | input | 1 | Discriminator hit bit for the current crossing |
| l1_trig_i | input | 1 | Level-1 trigger for the crossing being read back |
| clear_i | input | 1 | Flag erase request from readout |
| rd_sel_i | input | 1 | Readout select for this pixel (row and column chosen) |
| rd_data_o | output | 1 | Flag onto the read bus while selected |
| row_or_o | output | 1 | Contribution to the row OR line |
| col_or_o | output | 1 | Contribution to the column OR line |

## Verification
Two functions can land in the same cycle: a trigger match that sets the flag, and a selected clear that erases it. The bench provokes this by writing hits in two consecutive crossings. The first one sets the flag one lap later. In the very next cycle the trigger that catches the second hit is applied together with clear and select. The cycle-by-cycle model must then show the flag still set. Sticky holding, clears ignored without select, and the one-cycle match window are judged against the same model. A long random run crosses several pointer wraps.

// File: rtl/php_pkg.sv
package php_pkg;

  // Next ring position, wrapping at the ring depth.
  function automatic int unsigned ring_next(int unsigned pos, int unsigned depth);
    if (pos + 1 >= depth) return 0;
    return pos + 1;
  endfunction

  // Match decision for one cycle: a stored hit meets the trigger.
  function automatic logic is_match(logic stored_hit, logic trig);
    return stored_hit & trig;
  endfunction

endpackage

// File: rtl/php_ring_ctrl.sv
module php_ring_ctrl #(
  parameter int DEPTH = 120,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [PW-1:0] wr_pos,
  output logic [PW-1:0] rd_pos
);

  logic [PW-1:0] wr_next;

  assign wr_next = PW'(php_pkg::ring_next(int'(wr_pos), DEPTH));
  // Read-ahead: the cell after the write position is the oldest one.
  assign rd_pos  = wr_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_pos <= '0;
    else        wr_pos <= wr_next;
  end

  assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pos == PW'(DEPTH-1)) |=> (wr_pos == '0));

  assert_read_then_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (wr_pos == $past(rd_pos)));

  assert_pos_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(wr_pos) < DEPTH) && (rd_pos != wr_pos || DEPTH == 1));

endmodule

// File: rtl/php_hit_ring.sv
module php_hit_ring #(
  parameter int DEPTH = 120,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hit,
  input  logic [PW-1:0] wr_pos,
  input  logic [PW-1:0] rd_pos,
  output logic          rd_hit
);

  logic [DEPTH-1:0] cells;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    logic cell_we;
    assign cell_we = (wr_pos == PW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cells[g] <= 1'b0;
      else if (cell_we) cells[g] <= hit;
    end
  end

  assign rd_hit = cells[rd_pos];

  // Every cycle writes the hit bit, whatever its value.
  assert_write_every_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cells[$past(wr_pos)] == $past(hit)));

endmodule

// File: rtl/php_trig_latch.sv
module php_trig_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_hit,
  input  logic trig,
  input  logic clear,
  input  logic sel,
  output logic flag
);

  logic set_ev;
  logic clr_ev;

  assign set_ev = php_pkg::is_match(rd_hit, trig);
  assign clr_ev = clear & sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag <= 1'b0;
    else if (set_ev) flag <= 1'b1;
    else if (clr_ev) flag <= 1'b0;
  end

  assert_set_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(rd_hit && trig));

  assert_clear_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> $past(clear && sel));

  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && trig) |=> flag);

  assert_clear_works_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && clear && sel && !(rd_hit && trig)) |=> !flag);

  assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !(clear && sel)) |=> flag);

endmodule

// File: rtl/pixel_hit_pipeline.sv
module pixel_hit_pipeline #(
  parameter int DEPTH = 120,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hit_i,
  input  logic l1_trig_i,
  input  logic clear_i,
  input  logic rd_sel_i,
  output logic rd_data_o,
  output logic row_or_o,
  output logic col_or_o
);

  logic [PW-1:0] wr_pos;
  logic [PW-1:0] rd_pos;
  logic          rd_hit;
  logic          flag;

  php_ring_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_pos (wr_pos),
    .rd_pos (rd_pos)
  );

  php_hit_ring #(.DEPTH(DEPTH)) u_ring (
    .clk    (clk),
    .rst_n  (rst_n),
    .hit    (hit_i),
    .wr_pos (wr_pos),
    .rd_pos (rd_pos),
    .rd_hit (rd_hit)
  );

  php_trig_latch u_latch (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_hit (rd_hit),
    .trig   (l1_trig_i),
    .clear  (clear_i),
    .sel    (rd_sel_i),
    .flag   (flag)
  );

  assign row_or_o  = flag;
  assign col_or_o  = flag;
  assign rd_data_o = flag & rd_sel_i;

  assert_bus_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_sel_i |-> !rd_data_o);

  assert_ors_agree_R8: assert property (@(posedge clk) disable iff (!rst_n)
    row_or_o == col_or_o);

endmodule

// File: tb/pixel_hit_pipeline_tb.sv
module pixel_hit_pipeline_tb;
  localparam int DEPTH = 120;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hit = 1'b0, trig = 1'b0, clr = 1'b0, sel = 1'b0;
  logic rd_data, row_or, col_or;

  int n_chk = 0;
  int n_fail = 0;
  string phase = "R1";

  bit hist[$];
  bit m_flag = 1'b0;

  always #4 clk = ~clk;

  pixel_hit_pipeline #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .hit_i(hit), .l1_trig_i(trig),
    .clear_i(clr), .rd_sel_i(sel), .rd_data_o(rd_data),
    .row_or_o(row_or), .col_or_o(col_or)
  );

  function automatic void model_reset();
    hist.delete();
    for (int i = 0; i < DEPTH-1; i++) hist.push_back(1'b0);
    m_flag = 1'b0;
  endfunction

  initial model_reset();

  // Reference: a crossing written now comes back DEPTH-1 edges later.
  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      bit old;
      old = hist.pop_front();
      hist.push_back(hit);
      if (trig && old)     m_flag = 1'b1;
      else if (clr && sel) m_flag = 1'b0;
    end
  end

  task automatic check(string tag, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic cmp_all();
    check(phase, "row_or", row_or, m_flag);
    check(phase, "col_or", col_or, m_flag);
    check(phase, "rd_data", rd_data, m_flag & sel);
  endtask

  task automatic step(logic h, logic t, logic c, logic s);
    @(negedge clk);
    cmp_all();
    hit = h; trig = t; clr = c; sel = s;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0);
  endtask

  initial begin
    #400000000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", "row_or in reset", row_or, 1'b0);
    check("R1", "col_or in reset", col_or, 1'b0);
    check("R1", "rd_data in reset", rd_data, 1'b0);
    rst_n = 1'b1;
    // R1: trigger held a full lap over empty cells
    phase = "R1";
    for (int i = 0; i < DEPTH+2; i++) step(0, 1, 0, 0);
    step(0, 0, 0, 0);
    check("R1", "no match on empty ring", row_or, 1'b0);

    // R3: hit then trigger DEPTH-1 edges later
    phase = "R3";
    step(1, 0, 0, 0);
    idle(DEPTH-2);
    step(0, 1, 0, 0);
    step(0, 0, 0, 0);
    check("R3", "flag after matched trigger", row_or, 1'b1);

    // R6: clear without select ignored
    phase = "R6";
    step(0, 0, 1, 0);
    step(0, 0, 1, 0);
    step(0, 0, 0, 0);
    check("R6", "flag kept on unselected clear", row_or, 1'b1);

    // R8: read bus follows select
    phase = "R8";
    step(0, 0, 0, 1);
    step(0, 0, 0, 0);
    check("R8", "col_or equals flag", col_or, 1'b1);

    // R5: selected clear erases
    phase = "R5";
    step(0, 0, 1, 1);
    step(0, 0, 0, 0);
    check("R5", "flag erased by selected clear", row_or, 1'b0);

    // R4: off-by-one triggers miss
    phase = "R4";
    step(1, 0, 0, 0);
    idle(DEPTH-3);
    step(0, 1, 0, 0);
    step(0, 0, 0, 0);
    step(0, 1, 0, 0);
    step(0, 0, 0, 0);
    check("R4", "early and late triggers ignored", row_or, 1'b0);

    // R7: set and selected clear in the same cycle
    phase = "R7";
    step(1, 0, 0, 0);
    step(1, 0, 0, 0);
    idle(DEPTH-3);
    step(0, 1, 0, 0);
    step(0, 1, 1, 1);
    step(0, 0, 0, 0);
    check("R7", "set wins over clear", row_or, 1'b1);
    step(0, 0, 1, 1);
    step(0, 0, 0, 0);
    check("R5", "cleared after collision", row_or, 1'b0);

    // R2: random traffic across several wraps
    phase = "R2";
    for (int i = 0; i < 6*DEPTH; i++)
      step(1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 2) == 0),
           1'($urandom_range(0, 5) == 0), 1'($urandom_range(0, 1)));
    idle(2);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule